// File: doc/BRIEF.md
# DRAM power-up initialization sequencer

This block paces the clock-enable (CKE) pin of a DRAM device after the memory controller leaves reset, and then decides the state in which the controller starts work. A 32-bit configuration word holds a wait that runs before CKE rises, a wait that runs after CKE rises, and a two-bit start-up code. Both waits count in units of 2^UNIT_SHIFT clocks. The default of 10 gives 1024-clock units and a 22-bit down-counter.

When the start-up code asks for a full power-up, the block runs the first wait and raises CKE. It then runs the second wait and pulses `init_start` for one cycle, which hands control to an external mode-register routine. When that routine reports `init_done`, the block enters normal operation. The other codes skip the routine. The controller then goes straight to normal mode with CKE high, or to self-refresh with CKE low. The configuration word is static: it can only be changed while the controller is held in reset.

Top module: `dram_pwrup_seq`

## Requirements
- R1: After `rst_n` is asserted, `cfg_rdata` reads 0x0002004E.
- R2: A write (`cfg_we` high at a clock edge) while `core_rst` is high stores `cfg_wdata`, except bits 29:26 and 15:12, which always read as zero.
- R3: A write while `core_rst` is low leaves `cfg_rdata` unchanged.
- R4: While `core_rst` is high, `cke` is low and `op_state` is 0. The `op_state` codes are: 0 = waiting before CKE, 1 = waiting after CKE, 2 = initializing, 3 = normal, 4 = self-refresh.
- R5: With start-up code bits 31:30 equal to 00 or 10, `cke` first reads high after rising edge P*2^UNIT_SHIFT+1 counted from the release of `core_rst`, where P is bits 11:0. A value of 0 means the move happens at the first edge. At that point `op_state` is 1.
- R6: After the edge that raised CKE, `op_state` becomes 2 after rising edge Q*2^UNIT_SHIFT+1 counted from that edge, where Q is bits 25:16. In that same cycle `init_start` is high.
- R7: `init_start` is high for exactly one cycle. The block stays in state 2 until `init_done` is seen high at a clock edge, then enters state 3 with `cke` still high.
- R8: With start-up code 01, the first edge after release enters state 3 with `cke` high.
- R9: With start-up code 11, the first edge after release enters state 4 with `cke` low.
- R10: States 3 and 4 hold until `core_rst` rises. Raising `core_rst` returns the block to state 0 with `cke` low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; restores the configuration default |
| core_rst | input | 1 | Controller held in reset, active high; enables configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| init_done | input | 1 | External initialization routine finished |
| cke | output | 1 | DRAM clock-enable level |
| init_start | output | 1 | One-cycle request to start the initialization routine |
| op_state | output | 3 | Current state code |

## Verification
The bench sweeps every combination of pre-CKE field 0..3, post-CKE field 0..3, both run codes (00 and 10) and an `init_done` delay of 0..2 cycles. It uses a 4-clock unit, so every edge count can be checked exactly against P*4+1 and Q*4+1. The zero fields separate "move on at the next edge" from off-by-one counting. The two run codes show that the upper code bit has no effect when the lower bit is clear. The `init_done` delays show that the block waits for the handshake rather than for time. Separate runs with codes 01 and 11 check the CKE level and the held state for each skip path. All-ones writes, issued both inside and outside reset, probe the reserved bits and the write protection.

// File: rtl/dram_pwrup_seq.sv
module dram_pwrup_seq #(
  parameter int          UNIT_SHIFT = 10,
  parameter logic [31:0] CFG_RESET  = 32'h0002004E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        core_rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        init_done,
  output logic        cke,
  output logic        init_start,
  output logic [2:0]  op_state
);
  localparam int          CW       = 12 + UNIT_SHIFT;
  localparam logic [31:0] CFG_MASK = 32'hC3FF0FFF;

  typedef enum logic [2:0] {
    S_PRE  = 3'd0,
    S_POST = 3'd1,
    S_INIT = 3'd2,
    S_NORM = 3'd3,
    S_SREF = 3'd4
  } st_t;

  st_t         st;
  logic [31:0] cfg_q, cfg_d;
  logic [CW-1:0] cnt, pre_ld, post_ld;
  logic        fresh;

  assign cfg_d   = (core_rst && cfg_we) ? (cfg_wdata & CFG_MASK) : cfg_q;
  assign pre_ld  = {cfg_d[11:0], {UNIT_SHIFT{1'b0}}};
  assign post_ld = {2'b00, cfg_q[25:16], {UNIT_SHIFT{1'b0}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= CFG_RESET & CFG_MASK;
    else        cfg_q <= cfg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PRE; cnt <= '0; cke <= 1'b0; init_start <= 1'b0; fresh <= 1'b1;
    end else if (core_rst) begin
      st <= S_PRE; cnt <= pre_ld; cke <= 1'b0; init_start <= 1'b0; fresh <= 1'b1;
    end else begin
      init_start <= 1'b0;
      fresh      <= 1'b0;
      case (st)
        S_PRE:
          if (fresh && cfg_q[30]) begin
            st  <= cfg_q[31] ? S_SREF : S_NORM;
            cke <= ~cfg_q[31];
          end else if (cnt == '0) begin
            st  <= S_POST;
            cke <= 1'b1;
            cnt <= post_ld;
          end else cnt <= cnt - 1'b1;
        S_POST:
          if (cnt == '0) begin
            st         <= S_INIT;
            init_start <= 1'b1;
          end else cnt <= cnt - 1'b1;
        S_INIT:
          if (init_done) st <= S_NORM;
        default: ;
      endcase
    end
  end

  assign cfg_rdata = cfg_q;
  assign op_state  = st;

  AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (op_state == 3'd0 && !cke)); // R4
  AST_CFG_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst |=> $stable(cfg_rdata)); // R3
  AST_CKE_IN_POST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 3'd1) |-> cke); // R5
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> !init_start); // R7
  AST_START_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |-> (op_state == 3'd2)); // R6
  AST_SREF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 3'd4) |-> !cke); // R9
  AST_NORM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 3'd3 && !core_rst) |=> (op_state == 3'd3 && cke)); // R10
endmodule

// File: tb/sim_dram_pwrup_seq.sv
module sim_dram_pwrup_seq;
  localparam int SH = 2;
  localparam int U  = 1 << SH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, core_rst = 1'b1, cfg_we = 1'b0, init_done = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        cke, init_start;
  logic [2:0]  op_state;
  int          nchk = 0, nbad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dram_pwrup_seq #(.UNIT_SHIFT(SH)) u0 (
    .clk, .rst_n, .core_rst, .cfg_we, .cfg_wdata, .cfg_rdata,
    .init_done, .cke, .init_start, .op_state);

  task automatic check(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_seq(int p, int q, int mode, int dly);
    int n;
    wr({mode[1:0], 4'hF, q[9:0], 4'hF, p[11:0]});
    check("R2", cfg_rdata, {mode[1:0], 4'h0, q[9:0], 4'h0, p[11:0]});
    check("R4", {cke, op_state}, 0);
    core_rst = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!cke && n < 300);
    check("R5 cke edge", n, p * U + 1);
    check("R5 state", op_state, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (op_state != 3'd2 && n < 300);
    check("R6 init edge", n, q * U + 1);
    check("R6 pulse", init_start, 1);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check("R7 wait", {init_start, op_state}, 2);
    end
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    check("R7 normal", {cke, op_state}, {1'b1, 3'd3});
    repeat (2) @(negedge clk);
    check("R10 hold", {cke, op_state}, {1'b1, 3'd3});
    core_rst = 1'b1;
    @(negedge clk);
    check("R10 restart", {cke, op_state}, 0);
  endtask

  task automatic run_skip(int mode);
    wr({mode[1:0], 30'h3});
    core_rst = 1'b0;
    @(negedge clk);
    if (mode == 1) check("R8", {cke, op_state}, {1'b1, 3'd3});
    else           check("R9", {cke, op_state}, {1'b0, 3'd4});
    wr(32'hFFFF_FFFF);
    check("R3", cfg_rdata, {mode[1:0], 30'h3});
    repeat (4) @(negedge clk);
    if (mode == 1) check("R10 normal", {cke, op_state}, {1'b1, 3'd3});
    else           check("R10 sref", {cke, op_state}, {1'b0, 3'd4});
    core_rst = 1'b1;
    @(negedge clk);
    check("R10 restart", {cke, op_state}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", cfg_rdata, 32'h0002004E);
    check("R4", {cke, op_state}, 0);
    wr(32'hFFFF_FFFF);
    check("R2 reserved", cfg_rdata, 32'hC3FF0FFF);
    for (int m = 0; m < 3; m += 2)
      for (int p = 0; p < 4; p++)
        for (int q = 0; q < 4; q++)
          for (int d = 0; d < 3; d++)
            run_seq(p, q, m, d);
    run_skip(1);
    run_skip(3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule